// File: doc/BRIEF.md
# Two-Port Audio Interrupt Aggregator

This block collects the service requests of two audio ports, each of which has a playback (output) direction and a capture (input) direction. Each of the four request sources is a one-cycle pulse. A pulse sets a sticky bit in a status register. A source can raise the shared interrupt line only when its bit is enabled in both of two separate enable registers. Software clears status bits by writing zero to them.

The block also holds three control registers:
- a clock-release register with one bit per port;
- a reset-control register, which drives a global run bit and four port hold bits;
- an acknowledge bit inside the reset-control register. Writing this bit low and then high sends a one-cycle acknowledge pulse to the port logic.

All registers sit on a plain word bus. Writes take effect at the clock edge. Read data is combinational from the address while the read strobe is high. The shared registers begin at byte offset 0x200. The per-port register windows at 0x000 and 0x040 belong to other blocks, so they read as zero here.

Top module: `aud_irq_agg`

## Requirements
- R1: After reset, every register reads zero, and irqOut, ackPulse, clkEnA, clkEnB, coreRun and portHold are all low.
- R2: A pulse on evtIn[i] sets status bit 4*i. The mapping is: bit 0 is port A output, bit 4 is port A input, bit 8 is port B output, bit 12 is port B input. The status register is at 0x200, and the bit can be read back in the cycle after the pulse. The bit stays set until it is cleared.
- R3: A write to the status register clears each status bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. An event pulse in the same cycle as a clearing write wins, and its bit is set.
- R4: irqOut is active-high and rises one clock after a status bit is set whose bit is also set in both enable registers: the primary enable at 0x208 and the secondary enable at 0x20C. If either enable bit is clear, irqOut stays low.
- R5: Each enable register stores only bits 0, 4, 8 and 12. All other bits read as zero.
- R6: The clock register is at 0x204. Bit 0 drives clkEnA and bit 4 drives clkEnB. Other bits read as zero.
- R7: The reset-control register is at 0x210 and stores bits [7:0]. Bit 0 drives coreRun and bits [7:4] drive portHold[3:0]. Bits above 7 read as zero.
- R8: A write that takes bit 4 of the reset-control register from 0 to 1 makes ackPulse high for exactly the next cycle. Writing 1 when the bit is already 1 gives no pulse.
- R9: A read of any unmapped offset (including 0x000, 0x040 and 0x214) returns zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 10 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when not reading |
| evtIn | input | 4 | Event pulses: A out, A in, B out, B in |
| irqOut | output | 1 | Registered interrupt line, active high |
| clkEnA | output | 1 | Port A clock release |
| clkEnB | output | 1 | Port B clock release |
| coreRun | output | 1 | Global soft reset release |
| portHold | output | 4 | Port reset hold bits |
| ackPulse | output | 1 | One-cycle interrupt acknowledge |

## Verification
Results become visible at different times:
- Register contents, clock enables, coreRun and portHold are valid in the cycle after the write edge.
- Status is valid in the cycle after the event edge.
- irqOut lags status or an enable change by one more register, so it is due two edges after the stimulus.
- ackPulse is valid after the write edge and lasts one cycle only.

The bench drives inputs on the falling edge and samples after it. Reads are combinational, so they are checked without advancing the clock. Each interrupt check first waits one extra falling edge so that it lands in the cycle where irqOut is due.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  typedef struct packed {
    logic wrStat;
    logic wrClk;
    logic wrMaskP;
    logic wrMaskS;
    logic wrSrst;
    logic rdStat;
    logic rdClk;
    logic rdMaskP;
    logic rdMaskS;
    logic rdSrst;
  } regStrb_t;
endpackage

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
  import aud_irq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SHARED_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrb_t          strb
);
  localparam logic [ADDR_W-1:0] ADDR_STAT  = ADDR_W'(SHARED_BASE + 'h0);
  localparam logic [ADDR_W-1:0] ADDR_CLK   = ADDR_W'(SHARED_BASE + 'h4);
  localparam logic [ADDR_W-1:0] ADDR_MASKP = ADDR_W'(SHARED_BASE + 'h8);
  localparam logic [ADDR_W-1:0] ADDR_MASKS = ADDR_W'(SHARED_BASE + 'hC);
  localparam logic [ADDR_W-1:0] ADDR_SRST  = ADDR_W'(SHARED_BASE + 'h10);

  logic hitStat, hitClk, hitMaskP, hitMaskS, hitSrst;

  always_comb begin
    hitStat  = (busAddr == ADDR_STAT);
    hitClk   = (busAddr == ADDR_CLK);
    hitMaskP = (busAddr == ADDR_MASKP);
    hitMaskS = (busAddr == ADDR_MASKS);
    hitSrst  = (busAddr == ADDR_SRST);
    strb.wrStat  = busWr & hitStat;
    strb.wrClk   = busWr & hitClk;
    strb.wrMaskP = busWr & hitMaskP;
    strb.wrMaskS = busWr & hitMaskS;
    strb.wrSrst  = busWr & hitSrst;
    strb.rdStat  = busRd & hitStat;
    strb.rdClk   = busRd & hitClk;
    strb.rdMaskP = busRd & hitMaskP;
    strb.rdMaskS = busRd & hitMaskS;
    strb.rdSrst  = busRd & hitSrst;
  end

  // R9: a bus access selects at most one register
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStat, strb.wrClk, strb.wrMaskP, strb.wrMaskS, strb.wrSrst}));
endmodule

// File: rtl/aud_irq_dp.sv
module aud_irq_dp
  import aud_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 4,
  parameter int BIT_STRIDE = 4,
  parameter int SRST_W     = 8,
  parameter int ACK_BIT    = 4,
  parameter int CLKB_BIT   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              ackPulse,
  output logic [1:0]        clkEn,
  output logic [SRST_W-1:0] srstOut
);
  localparam int SPAN = NUM_SRC * BIT_STRIDE;

  logic [NUM_SRC-1:0] statQ, maskPQ, maskSQ, wrGather, statNext;
  logic [DATA_W-1:0]  statWide, maskPWide, maskSWide;
  logic [1:0]         clkQ;
  logic [SRST_W-1:0]  srstQ;
  logic               irqQ, ackQ;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign wrGather[i] = busWdata[i*BIT_STRIDE];
      assign statNext[i] = (strb.wrStat ? (statQ[i] & wrGather[i]) : statQ[i]) | evtIn[i];

      // R2: an event pulse sets its status bit
      assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
        evtIn[i] |=> statQ[i]);
      // R3: a zero written with no event clears the bit
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
        (strb.wrStat && !busWdata[i*BIT_STRIDE] && !evtIn[i]) |=> !statQ[i]);
    end
  endgenerate

  always_comb begin
    statWide  = '0;
    maskPWide = '0;
    maskSWide = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      statWide[i*BIT_STRIDE]  = statQ[i];
      maskPWide[i*BIT_STRIDE] = maskPQ[i];
      maskSWide[i*BIT_STRIDE] = maskSQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ  <= '0;
      maskPQ <= '0;
      maskSQ <= '0;
      clkQ   <= '0;
      srstQ  <= '0;
      irqQ   <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      statQ <= statNext;
      if (strb.wrMaskP) maskPQ <= wrGather;
      if (strb.wrMaskS) maskSQ <= wrGather;
      if (strb.wrClk)   clkQ   <= {busWdata[CLKB_BIT], busWdata[0]};
      if (strb.wrSrst)  srstQ  <= busWdata[SRST_W-1:0];
      irqQ <= |(statQ & maskPQ & maskSQ);
      ackQ <= strb.wrSrst & busWdata[ACK_BIT] & ~srstQ[ACK_BIT];
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdStat)  busRdata = statWide;
    if (strb.rdMaskP) busRdata = maskPWide;
    if (strb.rdMaskS) busRdata = maskSWide;
    if (strb.rdSrst)  busRdata[SRST_W-1:0] = srstQ;
    if (strb.rdClk) begin
      busRdata[0]        = clkQ[0];
      busRdata[CLKB_BIT] = clkQ[1];
    end
  end

  assign irqOut   = irqQ;
  assign ackPulse = ackQ;
  assign clkEn    = clkQ;
  assign srstOut  = srstQ;

  // R4: the line only rises for a doubly enabled pending event
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (($past(statQ) & $past(maskPQ) & $past(maskSQ)) != '0));
  // R8: acknowledge lasts one cycle
  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);
  // R8: acknowledge needs the bit to have been low before
  assert_ack_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (srstOut[ACK_BIT] && !$past(srstOut[ACK_BIT])));

  initial begin
    assert_span_fits: assert (SPAN <= DATA_W);
  end
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
  import aud_irq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int NUM_SRC     = 4,
  parameter int SHARED_BASE = 'h200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic               irqOut,
  output logic               clkEnA,
  output logic               clkEnB,
  output logic               coreRun,
  output logic [3:0]         portHold,
  output logic               ackPulse
);
  localparam int SRST_W = 8;

  regStrb_t          strb;
  logic [1:0]        clkEn;
  logic [SRST_W-1:0] srstQ;

  aud_irq_ctrl #(.ADDR_W(ADDR_W), .SHARED_BASE(SHARED_BASE)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .strb(strb)
  );

  aud_irq_dp #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .BIT_STRIDE(4),
               .SRST_W(SRST_W), .ACK_BIT(4), .CLKB_BIT(4)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .evtIn(evtIn), .busRdata(busRdata), .irqOut(irqOut),
    .ackPulse(ackPulse), .clkEn(clkEn), .srstOut(srstQ)
  );

  assign clkEnA   = clkEn[0];
  assign clkEnB   = clkEn[1];
  assign coreRun  = srstQ[0];
  assign portHold = srstQ[7:4];
endmodule

// File: tb/aud_irq_agg_tb.sv
module aud_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  evtIn = '0;
  logic        irqOut, clkEnA, clkEnB, coreRun, ackPulse;
  logic [3:0]  portHold;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  aud_irq_agg dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .irqOut(irqOut),
    .clkEnA(clkEnA), .clkEnB(clkEnB), .coreRun(coreRun), .portHold(portHold),
    .ackPulse(ackPulse)
  );

  localparam logic [11:0] A_STAT = 12'h200, A_CLK = 12'h204, A_MP = 12'h208,
                          A_MS = 12'h20C, A_SR = 12'h210;
  // vector: {req[3:0], op[3:0], addr[11:0], data[15:0], exp[15:0]}
  // op 1 write, 2 read-check, 3 event pulse, 4 irq check after one cycle
  localparam int NV = 26;
  localparam logic [51:0] VEC [NV] = '{
    {4'd5, 4'd1, A_MP, 16'h1111, 16'h0},     // R5
    {4'd5, 4'd2, A_MP, 16'h0, 16'h1111},
    {4'd5, 4'd1, A_MP, 16'hFFFF, 16'h0},
    {4'd5, 4'd2, A_MP, 16'h0, 16'h1111},
    {4'd5, 4'd1, A_MS, 16'h0101, 16'h0},
    {4'd5, 4'd2, A_MS, 16'h0, 16'h0101},
    {4'd2, 4'd3, 12'h0, 16'h1, 16'h0},       // R2 port A out
    {4'd2, 4'd2, A_STAT, 16'h0, 16'h0001},
    {4'd4, 4'd4, 12'h0, 16'h0, 16'h1},       // R4
    {4'd2, 4'd3, 12'h0, 16'h2, 16'h0},       // R2 port A in
    {4'd2, 4'd2, A_STAT, 16'h0, 16'h0011},
    {4'd3, 4'd1, A_STAT, 16'h0010, 16'h0},   // R3 selective clear
    {4'd3, 4'd2, A_STAT, 16'h0, 16'h0010},
    {4'd4, 4'd4, 12'h0, 16'h0, 16'h0},       // R4 bit4 lacks secondary enable
    {4'd2, 4'd3, 12'h0, 16'h4, 16'h0},       // R2 port B out
    {4'd2, 4'd2, A_STAT, 16'h0, 16'h0110},
    {4'd4, 4'd4, 12'h0, 16'h0, 16'h1},
    {4'd4, 4'd1, A_MS, 16'h0, 16'h0},
    {4'd4, 4'd4, 12'h0, 16'h0, 16'h0},
    {4'd2, 4'd3, 12'h0, 16'h8, 16'h0},       // R2 port B in
    {4'd2, 4'd2, A_STAT, 16'h0, 16'h1110},
    {4'd3, 4'd1, A_STAT, 16'h0, 16'h0},
    {4'd3, 4'd2, A_STAT, 16'h0, 16'h0},
    {4'd6, 4'd1, A_CLK, 16'hFFFF, 16'h0},    // R6
    {4'd6, 4'd2, A_CLK, 16'h0, 16'h0011},
    {4'd7, 4'd1, A_SR, 16'hFFFF, 16'h0}      // R7
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a[9:0]; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busRd = 1'b1; busAddr = a[9:0];
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic pulseEvt(input logic [3:0] e);
    @(negedge clk);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irqOut == 0 && ackPulse == 0, "R1 irq/ack", {irqOut, ackPulse}, 0);
    check({clkEnA, clkEnB, coreRun, portHold} == 0, "R1 controls",
          {clkEnA, clkEnB, coreRun, portHold}, 0);
    busRead(A_STAT, rd); check(rd == 0, "R1 status", rd, 0);
    busRead(A_MP, rd);   check(rd == 0, "R1 primary enable", rd, 0);
    busRead(A_SR, rd);   check(rd == 0, "R1 reset ctrl", rd, 0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k][51:48], k);
      case (VEC[k][47:44])
        4'd1: busWrite(VEC[k][43:32], {16'h0, VEC[k][31:16]});
        4'd2: begin
          busRead(VEC[k][43:32], rd);
          check(rd == {16'h0, VEC[k][15:0]}, tag, rd, VEC[k][15:0]);
        end
        4'd3: pulseEvt(VEC[k][19:16]);
        4'd4: begin
          @(negedge clk);
          check(irqOut == VEC[k][0], tag, irqOut, VEC[k][0]);
        end
        default: ;
      endcase
    end
    busRead(A_SR, rd); check(rd == 32'hFF, "R7 upper bits zero", rd, 32'hFF);

    // R6 clock outputs
    busWrite(A_CLK, 32'h10);
    check(clkEnA == 0 && clkEnB == 1, "R6 clkEn", {clkEnA, clkEnB}, 2'b01);
    // R7 reset-control outputs
    busWrite(A_SR, 32'h51);
    check(coreRun == 1 && portHold == 4'h5, "R7 outputs", {coreRun, portHold}, 5'h15);

    // R8 acknowledge edge
    busWrite(A_SR, 32'h00);
    check(ackPulse == 0, "R8 low write", ackPulse, 0);
    busWrite(A_SR, 32'h10);
    check(ackPulse == 1, "R8 pulse", ackPulse, 1);
    @(negedge clk);
    check(ackPulse == 0, "R8 one cycle", ackPulse, 0);
    busWrite(A_SR, 32'h10);
    check(ackPulse == 0, "R8 no repeat", ackPulse, 0);

    // R3 event beats clearing write in the same cycle
    @(negedge clk);
    evtIn = 4'h1; busWr = 1'b1; busAddr = A_STAT[9:0]; busWdata = 32'h0;
    @(negedge clk);
    evtIn = '0; busWr = 1'b0;
    busRead(A_STAT, rd); check(rd == 32'h1, "R3 event priority", rd, 1);

    // R4 only one enable set -> no irq, then secondary set -> irq
    @(negedge clk);
    check(irqOut == 0, "R4 single enable", irqOut, 0);
    busWrite(A_MS, 32'h1);
    @(negedge clk);
    check(irqOut == 1, "R4 both enables", irqOut, 1);

    // R9 unmapped offsets
    busWrite(12'h000, 32'hFFFF);
    busWrite(12'h040, 32'hFFFF);
    busWrite(12'h214, 32'hFFFF);
    busRead(12'h000, rd); check(rd == 0, "R9 read 0x000", rd, 0);
    busRead(12'h040, rd); check(rd == 0, "R9 read 0x040", rd, 0);
    busRead(12'h214, rd); check(rd == 0, "R9 read 0x214", rd, 0);
    busRead(A_MP, rd);   check(rd == 32'h1111, "R9 enable untouched", rd, 32'h1111);
    busRead(A_CLK, rd);  check(rd == 32'h10, "R9 clock untouched", rd, 32'h10);
    busRead(A_SR, rd);   check(rd == 32'h10, "R9 reset ctrl untouched", rd, 32'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule